// File: doc/BRIEF.md
# Transmit Queue to Channel Request Router

This block keeps the setup of sixteen transmit queues and turns it into one request line for each of eight prioritised transmit channels. Every queue has a small status word. That word holds an active flag, a 4-bit channel field, a window-space flag and an acknowledgement-mode flag. A queue wants service when it is active and its empty flag is clear. Its request goes to the one channel that its channel field names. A channel takes requests from any number of queues. It raises its request only when its own enable bit is set, and it reports the lowest-numbered queue that is requesting.

Configuration is written through a single write port. A kind code picks the register and a queue index picks the status word. The status word and the empty flags both use masked writes: the upper half of the write data says which lower bits may change. The same kind codes select a combinational read port. The block also holds a per-queue chain-mode register and a per-queue interrupt mask. The mask gates a pulse input that signals a read-pointer advance, and the result becomes a registered interrupt output.

Top module: `txq_chan_router`

## Requirements
- R1: After reset, every status word is 0, all sixteen empty flags are 1, and the channel enables, chain-mode bits and interrupt mask are 0. In the same state `chan_req`, `chan_qsel` and `irq_out` are 0.
- R2: Kind 0 writes the status word of queue `wr_queue`. Bit i of data bits 9:0 is taken only when data bit 10+i is 1. The field layout is: bit 0 is active, bits 4:1 are the channel, bit 5 is window-space-left and bit 8 is acknowledgement mode.
- R3: Status bits 6, 7 and 9 always read 0, even after a write that sets them with their enables set.
- R4: Kind 1 writes the empty flags. Data bits 15:0 are the new flags and data bits 31:16 are per-queue masks. Only masked-in flags change. A read returns the flags in bits 15:0.
- R5: `chan_req[c]` is 1 only when channel enable c is 1 and at least one queue is active, not empty and has channel field equal to c. A channel field of 8 to 15 reaches no channel.
- R6: `chan_qsel[4c+3:4c]` holds the lowest-numbered queue that qualifies for channel c, whether or not the channel is enabled. It is 0 when no queue qualifies.
- R7: Kind 2 writes the channel enables from data bits 7:0. A disabled channel raises no request.
- R8: Kind 3 writes the chain-mode bits and kind 4 writes the interrupt mask, each from data bits 15:0. Both read back in bits 15:0.
- R9: `irq_out[q]` is 1 in the cycle after `rdptr_adv[q]` was 1 while interrupt-mask bit q was set, and 0 otherwise.
- R10: The window-space and acknowledgement-mode bits are stored and read back but do not change requests or selections.
- R11: Kind codes 5 to 7 change no register on a write and read as 0. Reads show new register values in the cycle right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 3 | Register kind code of the write |
| wr_queue | input | 4 | Queue index for status writes |
| wr_data | input | 32 | Write data with mask half |
| rd_kind | input | 3 | Register kind code of the read |
| rd_queue | input | 4 | Queue index for status reads |
| rd_data | output | 32 | Read data, combinational |
| rdptr_adv | input | 16 | Per-queue read-pointer advance pulses |
| irq_out | output | 16 | Registered per-queue interrupts |
| chan_req | output | 8 | Per-channel request |
| chan_qsel | output | 32 | Per-channel selected queue, 4 bits each |

## Verification
The hardest state to reach is one where several queues point at the same channel and qualify at once, and the lowest of them then stops qualifying. The selection must then move to the next queue up, and it must not move if a queue only changes its window or acknowledgement bits. Directed sequences build this state on purpose. Random status writes keep the channel field mostly inside 0 to 9, so collisions happen often and out-of-range channels still appear. Random enable masks then flip single bits of a queue's state in the middle of a sequence.

// File: rtl/txq_router_pkg.sv
package txq_router_pkg;

    typedef enum logic [2:0] {
        K_STAT  = 3'd0,
        K_EMPTY = 3'd1,
        K_CHEN  = 3'd2,
        K_CHAIN = 3'd3,
        K_IRQM  = 3'd4
    } reg_kind_e;

    localparam int STAT_W     = 10;
    localparam int POS_ACTIVE = 0;
    localparam int POS_CHAN   = 1;
    localparam int CHAN_FW    = 4;
    localparam int POS_WLEFT  = 5;
    localparam int POS_ACKM   = 8;
    localparam int EN_OFS     = 10;
    localparam int MASK_OFS   = 16;

    // bits that hold state; the others read 0
    localparam logic [STAT_W-1:0] STAT_LIVE = 10'b01_0011_1111;

endpackage

// File: rtl/txq_lowest_pick.sv
module txq_lowest_pick #(
    parameter int N  = 16,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/txq_req_matrix.sv
module txq_req_matrix
    import txq_router_pkg::*;
#(
    parameter int NQ  = 16,
    parameter int NCH = 8,
    parameter int QW  = $clog2(NQ)
) (
    input  logic [NQ-1:0]         active,
    input  logic [NQ-1:0]         empty,
    input  logic [NQ*CHAN_FW-1:0] chan_fld,
    input  logic [NCH-1:0]        chen,
    output logic [NCH-1:0]        req,
    output logic [NCH*QW-1:0]     qsel
);
    logic [NQ-1:0] ready;
    assign ready = active & ~empty;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [NQ-1:0] hit;
        logic          any;
        for (genvar q = 0; q < NQ; q++) begin : g_q
            assign hit[q] = ready[q] && (chan_fld[q*CHAN_FW +: CHAN_FW] == CHAN_FW'(c));
        end
        txq_lowest_pick #(.N(NQ), .IW(QW)) u_pick (
            .vec (hit),
            .idx (qsel[c*QW +: QW]),
            .any (any)
        );
        assign req[c] = any & chen[c];
    end
endmodule

// File: rtl/txq_chan_router.sv
module txq_chan_router
    import txq_router_pkg::*;
#(
    parameter int NQ  = 16,
    parameter int NCH = 8,
    parameter int QW  = $clog2(NQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_kind,
    input  logic [QW-1:0]     wr_queue,
    input  logic [31:0]       wr_data,
    input  logic [2:0]        rd_kind,
    input  logic [QW-1:0]     rd_queue,
    output logic [31:0]       rd_data,
    input  logic [NQ-1:0]     rdptr_adv,
    output logic [NQ-1:0]     irq_out,
    output logic [NCH-1:0]    chan_req,
    output logic [NCH*QW-1:0] chan_qsel
);
    typedef struct packed {
        logic [NQ-1:0][STAT_W-1:0] stat;
        logic [NQ-1:0]             empty;
        logic [NCH-1:0]            chen;
        logic [NQ-1:0]             chain;
        logic [NQ-1:0]             irqm;
        logic [NQ-1:0]             irq;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        logic [STAT_W-1:0] en_bits;
        logic [NQ-1:0]     emask;
        st_d    = st_q;
        en_bits = wr_data[EN_OFS +: STAT_W];
        emask   = wr_data[MASK_OFS +: NQ];
        if (wr_en) begin
            case (wr_kind)
                K_STAT:  st_d.stat[wr_queue] = ((st_q.stat[wr_queue] & ~en_bits)
                                               | (wr_data[STAT_W-1:0] & en_bits)) & STAT_LIVE;
                K_EMPTY: st_d.empty = (st_q.empty & ~emask) | (wr_data[NQ-1:0] & emask);
                K_CHEN:  st_d.chen  = wr_data[NCH-1:0];
                K_CHAIN: st_d.chain = wr_data[NQ-1:0];
                K_IRQM:  st_d.irqm  = wr_data[NQ-1:0];
                default: ;
            endcase
        end
        st_d.irq = rdptr_adv & st_q.irqm;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.empty <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    logic [NQ-1:0]         active_v;
    logic [NQ*CHAN_FW-1:0] chan_v;
    logic [NQ*STAT_W-1:0]  stat_flat;
    logic [NQ-1:0]         empty_now;
    logic [NCH-1:0]        chen_now;

    for (genvar q = 0; q < NQ; q++) begin : g_unpack
        assign active_v[q]                   = st_q.stat[q][POS_ACTIVE];
        assign chan_v[q*CHAN_FW +: CHAN_FW]  = st_q.stat[q][POS_CHAN +: CHAN_FW];
        assign stat_flat[q*STAT_W +: STAT_W] = st_q.stat[q];
    end
    assign empty_now = st_q.empty;
    assign chen_now  = st_q.chen;

    txq_req_matrix #(.NQ(NQ), .NCH(NCH), .QW(QW)) u_matrix (
        .active   (active_v),
        .empty    (st_q.empty),
        .chan_fld (chan_v),
        .chen     (st_q.chen),
        .req      (chan_req),
        .qsel     (chan_qsel)
    );

    always_comb begin
        rd_data = '0;
        case (rd_kind)
            K_STAT:  rd_data[STAT_W-1:0] = st_q.stat[rd_queue];
            K_EMPTY: rd_data[NQ-1:0]     = st_q.empty;
            K_CHEN:  rd_data[NCH-1:0]    = st_q.chen;
            K_CHAIN: rd_data[NQ-1:0]     = st_q.chain;
            K_IRQM:  rd_data[NQ-1:0]     = st_q.irqm;
            default: rd_data             = '0;
        endcase
    end

    assign irq_out = st_q.irq;
endmodule

// File: rtl/txq_chan_router_chk.sv
module txq_chan_router_chk
    import txq_router_pkg::*;
#(
    parameter int NQ  = 16,
    parameter int NCH = 8,
    parameter int QW  = $clog2(NQ)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [2:0]           wr_kind,
    input logic [31:0]          wr_data,
    input logic [NQ-1:0]        rdptr_adv,
    input logic [NQ-1:0]        irq_out,
    input logic [NCH-1:0]       chan_req,
    input logic [NCH*QW-1:0]    chan_qsel,
    input logic [NQ*STAT_W-1:0] stat_flat,
    input logic [NQ-1:0]        empty_now,
    input logic [NCH-1:0]       chen_now
);
    // R7: a disabled channel never requests
    a_r7_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_req & ~chen_now) == '0);

    // R9: no interrupt without an advance pulse in the previous cycle
    a_r9_irq_follows_adv: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_out & ~$past(rdptr_adv)) == '0));

    // R4: flags outside the write mask keep their value
    a_r4_empty_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == K_EMPTY) |=>
        (((empty_now ^ $past(empty_now)) & ~$past(wr_data[MASK_OFS +: NQ])) == '0));

    for (genvar c = 0; c < NCH; c++) begin : g_c
        logic [QW-1:0]     sel;
        logic [STAT_W-1:0] sw;
        assign sel = chan_qsel[c*QW +: QW];
        assign sw  = stat_flat[sel*STAT_W +: STAT_W];
        // R5 / R6: the reported queue really qualifies for this channel
        a_r6_pick_qualifies: assert property (@(posedge clk) disable iff (!rst_n)
            chan_req[c] |-> (sw[POS_ACTIVE] && !empty_now[sel]
                             && sw[POS_CHAN +: CHAN_FW] == CHAN_FW'(c)));
    end

    for (genvar q = 0; q < NQ; q++) begin : g_q
        // R3: dead status bits stay 0
        a_r3_dead_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_flat[q*STAT_W + 6] | stat_flat[q*STAT_W + 7] | stat_flat[q*STAT_W + 9]) == 1'b0);
    end
endmodule

bind txq_chan_router txq_chan_router_chk #(.NQ(NQ), .NCH(NCH), .QW(QW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_kind   (wr_kind),
    .wr_data   (wr_data),
    .rdptr_adv (rdptr_adv),
    .irq_out   (irq_out),
    .chan_req  (chan_req),
    .chan_qsel (chan_qsel),
    .stat_flat (stat_flat),
    .empty_now (empty_now),
    .chen_now  (chen_now)
);

// File: tb/txq_chan_router_tb.sv
`timescale 1ns/1ps
module txq_chan_router_tb;
    localparam int NQ = 16, NCH = 8, QW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          wr_en = 1'b0;
    logic [2:0]    wr_kind = '0, rd_kind = '0;
    logic [3:0]    wr_queue = '0, rd_queue = '0;
    logic [31:0]   wr_data = '0, rd_data;
    logic [15:0]   rdptr_adv = '0, irq_out;
    logic [7:0]    chan_req;
    logic [31:0]   chan_qsel;

    txq_chan_router u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_queue(wr_queue), .wr_data(wr_data), .rd_kind(rd_kind),
        .rd_queue(rd_queue), .rd_data(rd_data), .rdptr_adv(rdptr_adv),
        .irq_out(irq_out), .chan_req(chan_req), .chan_qsel(chan_qsel)
    );

    logic [9:0]  m_stat [NQ];
    logic [15:0] m_empty, m_chain, m_mask;
    logic [7:0]  m_chen;
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] hits(input int c);
        logic [15:0] h = '0;
        for (int q = 0; q < NQ; q++)
            h[q] = m_stat[q][0] && !m_empty[q] && (m_stat[q][4:1] == 4'(c));
        return h;
    endfunction

    function automatic logic [7:0] e_req();
        logic [7:0] r;
        for (int c = 0; c < NCH; c++) r[c] = m_chen[c] && (hits(c) != 0);
        return r;
    endfunction

    function automatic logic [31:0] e_sel();
        logic [31:0] s = '0;
        for (int c = 0; c < NCH; c++) begin
            logic [15:0] h = hits(c);
            for (int q = NQ - 1; q >= 0; q--)
                if (h[q]) s[c*4 +: 4] = 4'(q);
        end
        return s;
    endfunction

    function automatic logic [31:0] e_read(input logic [2:0] k, input logic [3:0] q);
        case (k)
            3'd0: return {22'd0, m_stat[q]};
            3'd1: return {16'd0, m_empty};
            3'd2: return {24'd0, m_chen};
            3'd3: return {16'd0, m_chain};
            3'd4: return {16'd0, m_mask};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_write(input logic [2:0] k, input logic [3:0] q, input logic [31:0] d);
        case (k)
            3'd0: m_stat[q] = ((m_stat[q] & ~d[19:10]) | (d[9:0] & d[19:10])) & 10'h13F;
            3'd1: m_empty = (m_empty & ~d[31:16]) | (d[15:0] & d[31:16]);
            3'd2: m_chen = d[7:0];
            3'd3: m_chain = d[15:0];
            3'd4: m_mask = d[15:0];
            default: ;
        endcase
    endtask

    task automatic step(input logic we, input logic [2:0] k, input logic [3:0] q,
                        input logic [31:0] d, input logic [15:0] adv);
        logic [15:0] exp_irq;
        @(negedge clk);
        wr_en = we; wr_kind = k; wr_queue = q; wr_data = d; rdptr_adv = adv;
        exp_irq = adv & m_mask;
        @(negedge clk);
        wr_en = 1'b0; rdptr_adv = '0;
        if (we) model_write(k, q, d);
        chk("R9 irq_out", {16'd0, irq_out}, {16'd0, exp_irq});
        chk("R5 chan_req", {24'd0, chan_req}, {24'd0, e_req()});
        chk("R6 chan_qsel", chan_qsel, e_sel());
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] k, input logic [3:0] q);
        rd_kind = k; rd_queue = q;
        #1;
        chk(tag, rd_data, e_read(k, q));
    endtask

    // status write: value, enables
    function automatic logic [31:0] sw(input logic [9:0] v, input logic [9:0] en);
        return {12'd0, en, v};
    endfunction

    function automatic logic [9:0] sv(input bit act, input int ch);
        return {5'd0, 4'(ch), act};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int q = 0; q < NQ; q++) m_stat[q] = '0;
        m_empty = 16'hFFFF; m_chen = '0; m_chain = '0; m_mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 chan_req", {24'd0, chan_req}, 32'd0);
        chk("R1 chan_qsel", chan_qsel, 32'd0);
        chk("R1 irq_out", {16'd0, irq_out}, 32'd0);
        for (int k = 0; k < 5; k++) rd_chk("R1 reset read", 3'(k), 4'd9);

        // R7 enable all channels
        step(1, 3'd2, 0, 32'hFF, '0);
        rd_chk("R7 chen read", 3'd2, 0);
        // R2 queues 3 and 5 on channel 2
        step(1, 3'd0, 4'd5, sw(sv(1, 2), 10'h3FF), '0);
        step(1, 3'd0, 4'd3, sw(sv(1, 2), 10'h3FF), '0);
        rd_chk("R2 status q3", 3'd0, 4'd3);
        step(1, 3'd1, 0, 32'h0028_0000, '0);   // R4 clear empty of 3 and 5
        rd_chk("R4 empty read", 3'd1, 0);
        chk("R6 lowest of 3,5", {28'd0, chan_qsel[11:8]}, 32'd3);
        // R10 window / ack bits on queue 3 change nothing
        step(1, 3'd0, 4'd3, sw(10'h120, 10'h120), '0);
        chk("R10 sel kept", {28'd0, chan_qsel[11:8]}, 32'd3);
        rd_chk("R10 status q3", 3'd0, 4'd3);
        // R2 clear only active bit of queue 3
        step(1, 3'd0, 4'd3, sw(10'h000, 10'h001), '0);
        chk("R2 sel moves to 5", {28'd0, chan_qsel[11:8]}, 32'd5);
        rd_chk("R2 status after masked", 3'd0, 4'd3);
        // R3 dead bits
        step(1, 3'd0, 4'd7, sw(10'h2C0, 10'h2C0), '0);
        rd_chk("R3 dead bits", 3'd0, 4'd7);
        // R5 channel 12 reaches nothing
        step(1, 3'd0, 4'd7, sw(sv(1, 12), 10'h01F), '0);
        step(1, 3'd1, 0, 32'h0080_0000, '0);
        chk("R5 out of range", {24'd0, chan_req}, {24'd0, e_req()});
        // R4 mask zero leaves flags
        step(1, 3'd1, 0, 32'h0000_0000, '0);
        rd_chk("R4 mask zero", 3'd1, 0);
        // R7 disable channel 2
        step(1, 3'd2, 0, 32'hFB, '0);
        chk("R7 ch2 off", {31'd0, chan_req[2]}, 32'd0);
        // R8 chain and irq mask
        step(1, 3'd3, 0, 32'h0000_A5A5, '0);
        rd_chk("R8 chain", 3'd3, 0);
        step(1, 3'd4, 0, 32'h0000_0F0F, 16'hFFFF);
        rd_chk("R8 irq mask", 3'd4, 0);
        step(0, 3'd0, 0, 32'd0, 16'h3C3C);    // R9
        // R11 unused kinds
        step(1, 3'd5, 0, 32'hFFFF_FFFF, '0);
        rd_chk("R11 unused read", 3'd6, 0);
        for (int k = 0; k < 5; k++) rd_chk("R11 no side effect", 3'(k), 4'd5);

        // random
        for (int i = 0; i < 3000; i++) begin
            logic [2:0]  k = 3'($urandom_range(0, 5));
            logic [3:0]  q = 4'($urandom_range(0, 15));
            logic [31:0] d = $urandom;
            if (k == 3'd0) d[4:1] = 4'($urandom_range(0, 9));
            if (k == 3'd5 && ($urandom & 1)) k = 3'd0;
            step(($urandom % 8) != 0, k, q, d, 16'($urandom));
            rd_chk("R2 R4 R8 random read", 3'($urandom_range(0, 7)), 4'($urandom_range(0, 15)));
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule